// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

A single DMA channel that moves 32-bit words between a memory port with a registered read response and a device port. A channel-control register held in the block selects the direction, the address stepping and the sync mode. Setting the run and go bits together starts a transfer. The block returns to idle on its own when the transfer ends.

Block mode copies a programmed number of words. Memory-to-device reads each word and hands it to the device one cycle later. Device-to-memory reads the device and writes memory in the same cycle. List mode walks a chain of packets in memory. Each packet is a header word followed by payload words, and the header carries both the payload length and the address of the next packet. The chain stops at a header whose end bit is set.

FSM states: `S_IDLE`, `S_BLK_RD`, `S_BLK_PUT`, `S_BLK_GET`, `S_HDR_RD`, `S_HDR_TAKE`, `S_PAY_RD`, `S_PAY_PUT`, `S_LINK`, `S_FAULT`, `S_DONE`.

The transitions are:
- IDLE→BLK_RD for a block read to the device, IDLE→BLK_GET for a block write to memory, IDLE→HDR_RD for list mode, and IDLE→FAULT for an unsupported setting.
- BLK_RD→BLK_PUT, and BLK_PUT→BLK_RD, or BLK_PUT→DONE after the last word.
- BLK_GET→BLK_GET, or BLK_GET→DONE after the last word.
- HDR_RD→HDR_TAKE. HDR_TAKE→PAY_RD, or HDR_TAKE→LINK when the count is zero.
- PAY_RD→PAY_PUT. PAY_PUT→PAY_RD, or PAY_PUT→LINK after the last payload word.
- LINK→HDR_RD, or LINK→DONE when the end bit is set.
- FAULT→DONE, and DONE→IDLE.

Top module: `lldma_channel`

## Requirements
- R1: Every memory address is 24 bits wide. The start address is the base input bits 23:2 with bits 1:0 forced to zero, and base bits 31:24 are ignored.
- R2: In block mode the address advances by +4 per word. It advances by -4 when control bit 1 (step-down) is set. The address wraps within 24 bits, so 0x000000-4 gives 0xFFFFFC and 0xFFFFFC+4 gives 0x000000.
- R3: Block mode moves exactly the programmed count of words, and a count of 0 moves 2^CNT_W words. With each word, `xfer_left_o` gives the words still to move after it, ending at 0.
- R4: Control bit 0 set means memory-to-device. In that direction each word is read from memory and written to the device in the following cycle with the read data. Bit 0 clear means device-to-memory. In that direction `dev_rd_o` and `mem_wr_o` are asserted together, with `mem_wdata_o` equal to `dev_rdata_i`.
- R5: Control bits 5:4 select the mode: 0 is block, 1 is list. A list header carries the payload count in bits 31:24 and the next-packet address in bits 23:0. Payload words start at the header address +4 and always step by +4, whatever the step-down bit says. A count of zero moves no payload.
- R6: After a packet, the chain ends if bit 23 of the header's next-address field is set. Otherwise the next header is read at that field with bits 1:0 forced to zero.
- R7: A transfer starts when control bit 16 (run) and bit 20 (go) are both set in idle. Go is cleared in the start cycle. Run is cleared when the transfer finishes. `done_o` pulses for one cycle as `busy_o` falls.
- R8: List mode with bit 0 clear, and mode values 2 and 3, move no word. They set `err_o`, clear run and pulse `done_o`. `err_o` clears on the next accepted control write.
- R9: Control writes are ignored while a transfer is running, including in its start cycle.
- R10: After reset the control register is zero, `busy_o`, `done_o` and `err_o` are low, and no memory or device strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr_i | input | 32 | Base address register value |
| blk_count_i | input | CNT_W | Block-mode word count (0 means 2^CNT_W) |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| ctrl_q_o | output | 32 | Current control register contents |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at transfer end |
| err_o | output | 1 | Unsupported mode/direction was started |
| mem_rd_o | output | 1 | Memory read strobe (data returns next cycle) |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Registered memory read data |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data, valid with `dev_rd_o` |
| xfer_addr_o | output | 24 | Memory address of the current word |
| xfer_left_o | output | LEFT_W | Words remaining after the current one |

## Verification
The assertions assume that memory read data arrives exactly one cycle after `mem_rd_o`. They also assume that the device accepts a write or supplies read data in the same cycle as its strobe, with no backpressure. The bench meets this with a memory model that registers its read data on every strobed edge. Its device model returns a fresh counter value combinationally. The bench drives the control write only at idle, or deliberately during a run to check that it is ignored. It keeps list chains within the modelled 1 KB window, so that every header and payload address is distinct.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    // control register bit positions
    localparam int CB_TO_DEV    = 0;
    localparam int CB_STEP_DOWN = 1;
    localparam int CB_MODE_LO   = 4;
    localparam int CB_RUN       = 16;
    localparam int CB_GO        = 20;

    typedef enum logic [1:0] {
        MODE_BLOCK = 2'd0,
        MODE_LIST  = 2'd1,
        MODE_RSV2  = 2'd2,
        MODE_RSV3  = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BLK_RD,
        S_BLK_PUT,
        S_BLK_GET,
        S_HDR_RD,
        S_HDR_TAKE,
        S_PAY_RD,
        S_PAY_PUT,
        S_LINK,
        S_FAULT,
        S_DONE
    } state_e;

endpackage

// File: rtl/lldma_ctrl_reg.sv
module lldma_ctrl_reg
    import lldma_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         clr_go,
    input  logic         clr_run,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end else begin
            if (clr_go)  q[CB_GO]  <= 1'b0;
            if (clr_run) q[CB_RUN] <= 1'b0;
        end
    end

endmodule

// File: rtl/lldma_addr_step.sv
module lldma_addr_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic          down,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] STRIDE = AW'(4);

    // wraps naturally inside AW bits
    assign nxt = down ? (cur - STRIDE) : (cur + STRIDE);

endmodule

// File: rtl/lldma_hdr_split.sv
module lldma_hdr_split #(
    parameter int DW = 32,
    parameter int AW = 24
) (
    input  logic [DW-1:0]    word,
    output logic [DW-AW-1:0] cnt,
    output logic [AW-1:0]    link,
    output logic             last
);

    assign cnt  = word[DW-1:AW];
    assign link = word[AW-1:0];
    assign last = word[AW-1];

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 24,
    parameter int CNT_W  = 16,
    parameter int CTRL_W = 32,
    localparam int HCW   = DW - AW,
    localparam int LEFT_W = ((CNT_W + 1) > HCW) ? (CNT_W + 1) : HCW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     base_addr_i,
    input  logic [CNT_W-1:0]  blk_count_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_q_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              dev_wr_o,
    output logic              dev_rd_o,
    output logic [DW-1:0]     dev_wdata_o,
    input  logic [DW-1:0]     dev_rdata_i,
    output logic [AW-1:0]     xfer_addr_o,
    output logic [LEFT_W-1:0] xfer_left_o
);

    state_e              state_q, state_d;
    logic [AW-1:0]       cur_q;
    logic [LEFT_W-1:0]   rem_q;
    logic [AW-1:0]       link_q;
    logic                link_end_q;
    logic                err_q;
    logic                done_q;

    logic [CTRL_W-1:0]   ctrl_q;
    logic                start;
    logic                wr_ok;
    logic                clr_go;
    logic                clr_run;
    logic                step_down;
    logic [AW-1:0]       cur_step;
    logic [LEFT_W-1:0]   rem_dec;
    logic                last_word;
    logic [LEFT_W-1:0]   blk_load;
    logic [HCW-1:0]      hdr_cnt;
    logic [AW-1:0]       hdr_link;
    logic                hdr_last;
    mode_e               mode;
    logic                to_dev;
    logic                unused_bits;

    assign mode   = mode_e'(ctrl_q[CB_MODE_LO +: 2]);
    assign to_dev = ctrl_q[CB_TO_DEV];
    assign start  = (state_q == S_IDLE) && ctrl_q[CB_RUN] && ctrl_q[CB_GO];
    assign wr_ok  = ctrl_wr_i && (state_q == S_IDLE) && !start;

    assign rem_dec   = rem_q - LEFT_W'(1);
    assign last_word = (rem_dec == '0);
    assign blk_load  = (blk_count_i == '0) ? (LEFT_W'(1) << CNT_W)
                                           : LEFT_W'(blk_count_i);

    assign unused_bits = ^{base_addr_i[DW-1:AW], base_addr_i[1:0], link_q[1:0]};

    lldma_ctrl_reg #(.W(CTRL_W)) ctrl_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wdata   (ctrl_wdata_i),
        .clr_go  (clr_go),
        .clr_run (clr_run),
        .q       (ctrl_q)
    );

    lldma_addr_step #(.AW(AW)) step_i (
        .cur  (cur_q),
        .down (step_down),
        .nxt  (cur_step)
    );

    lldma_hdr_split #(.DW(DW), .AW(AW)) hdr_i (
        .word (mem_rdata_i),
        .cnt  (hdr_cnt),
        .link (hdr_link),
        .last (hdr_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (mode == MODE_BLOCK)            state_d = to_dev ? S_BLK_RD : S_BLK_GET;
                    else if (mode == MODE_LIST && to_dev) state_d = S_HDR_RD;
                    else                               state_d = S_FAULT;
                end
            end
            S_BLK_RD:   state_d = S_BLK_PUT;
            S_BLK_PUT:  state_d = last_word ? S_DONE : S_BLK_RD;
            S_BLK_GET:  state_d = last_word ? S_DONE : S_BLK_GET;
            S_HDR_RD:   state_d = S_HDR_TAKE;
            S_HDR_TAKE: state_d = (hdr_cnt == '0) ? S_LINK : S_PAY_RD;
            S_PAY_RD:   state_d = S_PAY_PUT;
            S_PAY_PUT:  state_d = last_word ? S_LINK : S_PAY_RD;
            S_LINK:     state_d = link_end_q ? S_DONE : S_HDR_RD;
            S_FAULT:    state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_o  = 1'b0;
        mem_wr_o  = 1'b0;
        dev_wr_o  = 1'b0;
        dev_rd_o  = 1'b0;
        clr_run   = 1'b0;
        step_down = 1'b0;
        clr_go    = start;
        unique case (state_q)
            S_BLK_RD, S_HDR_RD, S_PAY_RD: mem_rd_o = 1'b1;
            S_BLK_PUT: begin
                dev_wr_o  = 1'b1;
                step_down = ctrl_q[CB_STEP_DOWN];
            end
            S_BLK_GET: begin
                dev_rd_o  = 1'b1;
                mem_wr_o  = 1'b1;
                step_down = ctrl_q[CB_STEP_DOWN];
            end
            S_PAY_PUT: dev_wr_o = 1'b1;
            S_DONE:    clr_run  = 1'b1;
            S_IDLE, S_HDR_TAKE, S_LINK, S_FAULT: ;
            default: ;
        endcase
    end

    assign mem_addr_o  = cur_q;
    assign mem_wdata_o = dev_rdata_i;
    assign dev_wdata_o = mem_rdata_i;
    assign xfer_addr_o = cur_q;
    assign xfer_left_o = rem_dec;
    assign ctrl_q_o    = ctrl_q;
    assign busy_o      = (state_q != S_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            rem_q      <= '0;
            link_q     <= '0;
            link_end_q <= 1'b0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (state_q == S_DONE);
            if (wr_ok) err_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cur_q <= {base_addr_i[AW-1:2], 2'b00};
                        rem_q <= blk_load;
                    end
                end
                S_BLK_PUT, S_BLK_GET, S_PAY_PUT: begin
                    cur_q <= cur_step;
                    rem_q <= rem_dec;
                end
                S_HDR_TAKE: begin
                    cur_q      <= cur_step;
                    rem_q      <= LEFT_W'(hdr_cnt);
                    link_q     <= hdr_link;
                    link_end_q <= hdr_last;
                end
                S_LINK:  cur_q <= {link_q[AW-1:2], 2'b00};
                S_FAULT: err_q <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk
    import lldma_pkg::*;
#(
    parameter int AW     = 24,
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic              dev_rd_o,
    input logic              dev_wr_o,
    input logic [AW-1:0]     mem_addr_o,
    input logic [CTRL_W-1:0] ctrl_q_o
);

    // R4
    dev_put_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_o |-> $past(mem_rd_o));

    // R4
    get_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_o |-> (mem_wr_o && !mem_rd_o && !dev_wr_o));

    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    go_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !ctrl_q_o[CB_GO]);

    // R9
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ctrl_q_o));

    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (mem_addr_o[1:0] == 2'b00));

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_rd_o || mem_wr_o || dev_rd_o || dev_wr_o));

endmodule

bind lldma_channel lldma_channel_chk #(.AW(AW), .CTRL_W(CTRL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .dev_rd_o   (dev_rd_o),
    .dev_wr_o   (dev_wr_o),
    .mem_addr_o (mem_addr_o),
    .ctrl_q_o   (ctrl_q_o)
);

// File: tb/lldma_channel_tb_top.sv
module lldma_channel_tb_top;

    localparam int CNT_W  = 8;
    localparam int LEFT_W = 9;

    localparam logic [31:0] C_DEV  = 32'h1;
    localparam logic [31:0] C_DOWN = 32'h2;
    localparam logic [31:0] C_LIST = 32'h10;
    localparam logic [31:0] C_M2   = 32'h20;
    localparam logic [31:0] C_RUN  = 32'h1_0000;
    localparam logic [31:0] C_GO   = 32'h10_0000;
    localparam logic [31:0] C_ST   = C_RUN | C_GO;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] ctrl;
        logic [7:0]  cnt;
        logic [23:0] first;
        logic [23:0] last;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{32'h0000_0103, C_ST | C_DEV,          8'd3, 24'h000100, 24'h000108, 16'd3},
        '{32'h0000_0200, C_ST | C_DEV | C_DOWN, 8'd4, 24'h000200, 24'h0001F4, 16'd4},
        '{32'h0000_0004, C_ST | C_DEV | C_DOWN, 8'd3, 24'h000004, 24'hFFFFFC, 16'd3},
        '{32'h00FF_FFF8, C_ST | C_DEV,          8'd3, 24'hFFFFF8, 24'h000000, 16'd3},
        '{32'hAB00_0042, C_ST | C_DEV,          8'd2, 24'h000040, 24'h000044, 16'd2},
        '{32'h0000_0010, C_ST | C_DEV,          8'd1, 24'h000010, 24'h000010, 16'd1},
        '{32'h0000_0300, C_ST,                  8'd5, 24'h000300, 24'h000310, 16'd5},
        '{32'h0000_03F0, C_ST | C_DOWN,         8'd2, 24'h0003F0, 24'h0003EC, 16'd2},
        '{32'h0000_0000, C_ST,                  8'd0, 24'h000000, 24'h0003FC, 16'd256}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       base_addr;
    logic [CNT_W-1:0]  blk_count;
    logic              ctrl_wr;
    logic [31:0]       ctrl_wdata;
    logic [31:0]       ctrl_q;
    logic              busy, done, err;
    logic              mem_rd, mem_wr, dev_wr, dev_rd;
    logic [23:0]       mem_addr, xfer_addr;
    logic [31:0]       mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [LEFT_W-1:0] xfer_left;

    always #2 clk = ~clk;

    lldma_channel #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr_i  (base_addr),
        .blk_count_i  (blk_count),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_wdata_i (ctrl_wdata),
        .ctrl_q_o     (ctrl_q),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_rdata_i  (mem_rdata),
        .dev_wr_o     (dev_wr),
        .dev_rd_o     (dev_rd),
        .dev_wdata_o  (dev_wdata),
        .dev_rdata_i  (dev_rdata),
        .xfer_addr_o  (xfer_addr),
        .xfer_left_o  (xfer_left)
    );

    // memory and device models
    logic [31:0] mem [256];
    logic [31:0] dev_k = 0;
    assign dev_rdata = 32'hD000_0000 + dev_k;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (dev_rd) dev_k <= dev_k + 1;
    end

    // event monitor
    logic [23:0] ev_addr [300];
    int          ev_left [300];
    int          ev_n = 0;
    int          bad = 0;
    int          done_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_wr || mem_wr) begin
                if (ev_n < 300) begin
                    ev_addr[ev_n] = xfer_addr;
                    ev_left[ev_n] = int'(xfer_left);
                end
                ev_n = ev_n + 1;
            end
            if (dev_wr && dev_wdata != mem[xfer_addr[9:2]]) bad = bad + 1;
            if (mem_wr && (!dev_rd || mem_wdata != dev_rdata)) bad = bad + 1;
            if (done) done_n = done_n + 1;
        end
    end

    int total = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic preset_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    endtask

    task automatic write_ctrl(input logic [31:0] v);
        @(negedge clk);
        ctrl_wdata = v;
        ctrl_wr    = 1'b1;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (done_n == 0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(done_n == 1, "R7 done pulse count", done_n, 1);
        @(negedge clk);
    endtask

    task automatic clear_log();
        @(negedge clk);
        ev_n = 0; bad = 0; done_n = 0;
    endtask

    task automatic run(input logic [31:0] b, input logic [31:0] c, input logic [7:0] n);
        clear_log();
        base_addr = b;
        blk_count = n;
        write_ctrl(c);
        wait_done();
    endtask

    task automatic check_chain(input string tag);
        logic [23:0] ea [5];
        int          el [5];
        ea = '{24'h84, 24'h88, 24'hA4, 24'hA8, 24'hAC};
        el = '{1, 0, 2, 1, 0};
        chk(ev_n == 5, {tag, " R5 payload count"}, ev_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk(ev_addr[i] == ea[i], {tag, " R6 payload addr"}, ev_addr[i], ea[i]);
            chk(ev_left[i] == el[i], {tag, " R5 words left"}, ev_left[i], el[i]);
        end
        chk(bad == 0, {tag, " R4 payload data"}, bad, 0);
    endtask

    initial begin
        base_addr  = '0;
        blk_count  = '0;
        ctrl_wr    = 1'b0;
        ctrl_wdata = '0;
        preset_mem();
        repeat (3) @(negedge clk);

        // R10 reset state
        chk(ctrl_q == 0, "R10 ctrl reset", ctrl_q, 0);
        chk(!busy && !done && !err, "R10 status reset", {busy, done, err}, 0);
        chk(!mem_rd && !mem_wr && !dev_rd && !dev_wr, "R10 strobes reset",
            {mem_rd, mem_wr, dev_rd, dev_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of block transfers
        for (int v = 0; v < 9; v++) begin
            run(VEC[v].base, VEC[v].ctrl, VEC[v].cnt);
            chk(ev_n == int'(VEC[v].n), "R3 word count", ev_n, VEC[v].n);
            chk(ev_addr[0] == VEC[v].first, "R1 start address", ev_addr[0], VEC[v].first);
            chk(ev_addr[VEC[v].n - 1] == VEC[v].last, "R2 last address",
                ev_addr[VEC[v].n - 1], VEC[v].last);
            chk(ev_left[0] == int'(VEC[v].n) - 1, "R3 first left", ev_left[0], VEC[v].n - 1);
            chk(ev_left[VEC[v].n - 1] == 0, "R3 last left", ev_left[VEC[v].n - 1], 0);
            chk(bad == 0, "R4 data path", bad, 0);
            chk((ctrl_q & C_ST) == 0, "R7 run/go cleared", ctrl_q, ctrl_q & ~C_ST);
            chk(!err, "R8 no error", err, 0);
        end

        // R7 go cleared in start cycle, busy while running
        preset_mem();
        clear_log();
        base_addr = 32'h100;
        blk_count = 8'd3;
        write_ctrl(C_ST | C_DEV);
        @(negedge clk);
        chk(ctrl_q[20] == 1'b0, "R7 go cleared at start", ctrl_q[20], 0);
        chk(ctrl_q[16] == 1'b1, "R7 run held while busy", ctrl_q[16], 1);
        chk(busy, "R7 busy", busy, 1);
        wait_done();
        chk(!busy, "R7 idle after done", busy, 0);

        // R5 R6 list chain
        preset_mem();
        mem[8'h20] = 32'h0200_00C0;
        mem[8'h30] = 32'h0000_00A0;
        mem[8'h28] = 32'h0380_0000;
        run(32'h80, C_ST | C_DEV | C_LIST, 8'd0);
        check_chain("chain");
        run(32'h80, C_ST | C_DEV | C_LIST | C_DOWN, 8'd0);
        check_chain("chain-down");

        // R6 unaligned link, end marker with other bits
        mem[8'h10] = 32'h0100_0062;
        mem[8'h18] = 32'h00FF_1234;
        run(32'h40, C_ST | C_DEV | C_LIST, 8'd0);
        chk(ev_n == 1, "R6 end marker stops chain", ev_n, 1);
        chk(ev_addr[0] == 24'h44, "R6 payload addr", ev_addr[0], 24'h44);
        chk(ev_left[0] == 0, "R5 single left", ev_left[0], 0);

        // R8 list with device-to-memory
        run(32'h80, C_ST | C_LIST, 8'd0);
        chk(ev_n == 0, "R8 no transfer", ev_n, 0);
        chk(err, "R8 error set", err, 1);
        chk(ctrl_q[16] == 0, "R8 run cleared", ctrl_q[16], 0);
        write_ctrl(32'h0);
        @(negedge clk);
        chk(!err, "R8 error cleared by write", err, 0);
        run(32'h80, C_ST | C_DEV | C_M2, 8'd2);
        chk(ev_n == 0 && err, "R8 reserved mode fault", {ev_n[30:0], err}, 1);

        // R9 write ignored while running
        clear_log();
        base_addr = 32'h0;
        blk_count = 8'd0;
        write_ctrl(C_ST | C_DEV);
        repeat (20) @(negedge clk);
        write_ctrl(32'h0);
        wait_done();
        chk(ev_n == 256, "R9 transfer unaffected", ev_n, 256);
        chk(ctrl_q == C_DEV, "R9 ctrl kept", ctrl_q, C_DEV);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule